// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with CPU Port

This core joins an 8-bit CPU port to a serial line. It frames outgoing characters on a transmit pin and deframes incoming characters from a receive pin. The CPU drives a chip select, active-low read and write strobes, and a select input that picks either the data path or the control/status path. All bus inputs are synchronous to `clk`. An access takes effect on the first clock where its strobe is low with chip select low (the leading edge).

The control address has two meanings. After an external reset, or after an internal-reset command, the next control write is the mode byte. The mode byte fixes the divide factor, character length, parity and stop length. Every later control write is a command byte. A command enables the transmitter and receiver, drives the two modem outputs, clears error flags, forces a break, or requests an internal reset.

All serial timing runs from `baud_tick`. This is a one-cycle clock enable at the bit rate times the divide factor, so one bit lasts 1, 16 or 64 ticks. The receiver checks a start bit at its middle sample and samples every later bit at mid-period.

Top module: `usart_core`

## Requirements
- R1: With `cmd_sel` low, a write loads the transmit holding register and a read returns the last received character. Characters shorter than 8 bits are zero-extended.
  With `cmd_sel` high, a read returns the status byte:
  - bit0: transmit buffer free
  - bit1: received character waiting
  - bit2: transmitter empty
  - bit3: parity error
  - bit4: overrun
  - bit5: framing error
  - bit6: break detected
  - bit7: always 0
- R2: After reset or a command with bit6 set, the next control write is taken as the mode byte. Every later control write is a command that replaces all command bits.
  The internal-reset command clears all command bits and empties the transmitter and receiver. It also clears the flags, so status reads 0x05.
- R3: Mode byte fields:
  - [1:0] divide factor: 10 = x16, 11 = x64, any other value = x1.
  - [3:2] character length = 5 + value.
  - [4] parity enable.
  - [5] even parity.
  - [7:6] stop length: 10 = 1.5 bits, 11 = 2 bits, any other value = 1 bit.
- R4: `txd` is high after reset and while command bit0 (transmit enable) is clear. Command bit3 (break) forces `txd` low.
- R5: The `tx_ready` pin is high only when the holding register is free, transmit is enabled and `cts_n` is low. Status bit0 shows only that the register is free. Both go low on the cycle after a data write.
- R6: `tx_empty` is high when the holding register is free and no frame is being sent. It goes low on the cycle after a data write.
- R7: A frame starts only while `cts_n` is low. It is sent as a low start bit, then the data bits LSB first, then the optional parity bit, then the stop time. Each bit lasts one bit period of ticks.
- R8: With command bit2 (receive enable) set, a received character sets `rx_ready` and status bit1. A data read clears them on the following cycle.
- R9: If a character completes while the previous one is still unread, the new character replaces it and the overrun flag is set.
- R10: A low first stop bit sets the framing flag. A parity mismatch sets the parity flag. Command bit4 clears all three error flags.
- R11: `brk_det` rises when `rxd` was low for every sample of a character, including its stop bit. It falls on the cycle after `rxd` is high, and it is low after reset.
- R12: `dtr_n` and `rts_n` are the inverses of command bits 1 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cmd_sel | input | 1 | 0 = data path, 1 = control/status |
| din | input | 8 | Write data from CPU |
| dout | output | 8 | Read data to CPU |
| baud_tick | input | 1 | Serial clock enable at the rate multiple |
| rxd | input | 1 | Serial receive line |
| cts_n | input | 1 | Clear-to-send, active low |
| txd | output | 1 | Serial transmit line |
| tx_ready | output | 1 | Transmitter can take a character |
| tx_empty | output | 1 | Nothing left to send |
| rx_ready | output | 1 | Received character waiting |
| brk_det | output | 1 | Break seen on the receive line |
| dtr_n | output | 1 | Modem data-terminal-ready, active low |
| rts_n | output | 1 | Modem request-to-send, active low |

## Verification
The hardest cases are the receive timings that depend on where a sample falls relative to line changes: mid-bit sampling at each divide factor, a character finishing while the last one is unread, and a line held low past a full frame. The bench drives `rxd` itself, one bit period per bit, to build frames with a wrong parity bit, a low stop bit, two frames back to back, and a held-low break. It then sweeps every mode byte through a loopback from `txd` to `rxd`, changing format each time with the internal-reset command.

// File: rtl/usart_pkg.sv
package usart_pkg;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam logic [CW-1:0] ONE = CW'(1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} ser_state_e;

  typedef struct packed {
    logic [1:0] stop;
    logic       even;
    logic       par_en;
    logic [1:0] len;
    logic [1:0] div;
  } mode_t;

  function automatic logic [CW-1:0] bit_ticks(input logic [1:0] div);
    case (div)
      2'b10:   return CW'(16);
      2'b11:   return CW'(64);
      default: return CW'(1);
    endcase
  endfunction

  function automatic logic [CW-1:0] stop_ticks(input logic [1:0] div, input logic [1:0] stop);
    logic [CW-1:0] p;
    p = bit_ticks(div);
    case (stop)
      2'b10:   return p + (p >> 1);
      2'b11:   return p << 1;
      default: return p;
    endcase
  endfunction

  function automatic logic [3:0] char_bits(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  function automatic logic [DW-1:0] char_mask(input logic [DW-1:0] data, input logic [1:0] len);
    logic [1:0] sh;
    sh = ~len;
    return data & ({DW{1'b1}} >> sh);
  endfunction

  function automatic logic parity_of(input logic [DW-1:0] data, input logic [1:0] len,
                                     input logic even);
    logic p;
    p = ^char_mask(data, len);
    return even ? p : ~p;
  endfunction
endpackage

// File: rtl/usart_ctrl.sv
module usart_ctrl
  import usart_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_wr,
  input  logic [DW-1:0] din,
  output mode_t         mode,
  output logic          tx_en,
  output logic          rx_en,
  output logic          brk,
  output logic          dtr,
  output logic          rts,
  output logic          err_clr,
  output logic          soft_rst
);
  logic expect_mode;
  logic cmd_wr;

  assign cmd_wr   = ctrl_wr && !expect_mode;
  assign err_clr  = cmd_wr && din[4];
  assign soft_rst = cmd_wr && din[6];

  always_ff @(posedge clk) begin
    if (rst) begin
      expect_mode <= 1'b1;
      mode  <= '0;
      tx_en <= 1'b0; rx_en <= 1'b0; brk <= 1'b0; dtr <= 1'b0; rts <= 1'b0;
    end else if (ctrl_wr) begin
      if (expect_mode) begin
        mode        <= mode_t'(din);
        expect_mode <= 1'b0;
      end else if (din[6]) begin
        expect_mode <= 1'b1;
        tx_en <= 1'b0; rx_en <= 1'b0; brk <= 1'b0; dtr <= 1'b0; rts <= 1'b0;
      end else begin
        tx_en <= din[0];
        dtr   <= din[1];
        rx_en <= din[2];
        brk   <= din[3];
        rts   <= din[5];
      end
    end
  end

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |=> $stable(mode)); // R2
endmodule

// File: rtl/usart_tx.sv
module usart_tx
  import usart_pkg::*;
(
  input  logic          clk,
  input  logic          clr,
  input  logic          tick,
  input  mode_t         mode,
  input  logic          tx_en,
  input  logic          cts_n,
  input  logic          brk,
  input  logic          data_wr,
  input  logic [DW-1:0] din,
  output logic          txd,
  output logic          buf_full,
  output logic          tx_empty
);
  ser_state_e    st;
  logic [DW-1:0] hold, shreg;
  logic          par_bit, line, last_bit;
  logic [CW-1:0] cnt, p;
  logic [2:0]    idx;

  assign p        = bit_ticks(mode.div);
  assign last_bit = ({1'b0, idx} == char_bits(mode.len) - 4'd1);

  always_ff @(posedge clk) begin
    if (clr) begin
      st <= S_IDLE; hold <= '0; shreg <= '0; par_bit <= 1'b0;
      cnt <= '0; idx <= '0; buf_full <= 1'b0;
    end else begin
      if (!tx_en) st <= S_IDLE;
      else if (tick) begin
        case (st)
          S_IDLE: if (buf_full && !cts_n) begin
            shreg    <= char_mask(hold, mode.len);
            par_bit  <= parity_of(hold, mode.len, mode.even);
            buf_full <= 1'b0;
            cnt      <= p - ONE;
            st       <= S_START;
          end
          S_START: if (cnt == '0) begin
            st <= S_DATA; idx <= '0; cnt <= p - ONE;
          end else cnt <= cnt - ONE;
          S_DATA: if (cnt == '0) begin
            if (last_bit) begin
              st  <= mode.par_en ? S_PAR : S_STOP;
              cnt <= mode.par_en ? p - ONE : stop_ticks(mode.div, mode.stop) - ONE;
            end else begin
              idx <= idx + 3'd1; shreg <= shreg >> 1; cnt <= p - ONE;
            end
          end else cnt <= cnt - ONE;
          S_PAR: if (cnt == '0) begin
            st <= S_STOP; cnt <= stop_ticks(mode.div, mode.stop) - ONE;
          end else cnt <= cnt - ONE;
          S_STOP: if (cnt == '0) st <= S_IDLE;
                  else cnt <= cnt - ONE;
          default: st <= S_IDLE;
        endcase
      end
      if (data_wr) begin
        hold <= din; buf_full <= 1'b1;
      end
    end
  end

  always_comb begin
    case (st)
      S_START: line = 1'b0;
      S_DATA:  line = shreg[0];
      S_PAR:   line = par_bit;
      default: line = 1'b1;
    endcase
  end

  assign txd      = brk ? 1'b0 : line;
  assign tx_empty = !buf_full && (st == S_IDLE);
endmodule

// File: rtl/usart_rx.sv
module usart_rx
  import usart_pkg::*;
(
  input  logic          clk,
  input  logic          clr,
  input  logic          tick,
  input  logic [1:0]    div,
  input  logic [1:0]    len,
  input  logic          par_en,
  input  logic          even,
  input  logic          rx_en,
  input  logic          rxd,
  input  logic          data_rd,
  input  logic          err_clr,
  output logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          par_err,
  output logic          ovr_err,
  output logic          frm_err,
  output logic          brk_det,
  output logic          char_done
);
  ser_state_e    st;
  logic [DW-1:0] shreg;
  logic [CW-1:0] cnt, p, half;
  logic [2:0]    idx;
  logic          armed, all_low, par_rx, last_bit;

  assign p         = bit_ticks(div);
  assign half      = p >> 1;
  assign last_bit  = ({1'b0, idx} == char_bits(len) - 4'd1);
  assign char_done = rx_en && tick && (st == S_STOP) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (clr) begin
      st <= S_IDLE; shreg <= '0; cnt <= '0; idx <= '0; armed <= 1'b0;
      all_low <= 1'b0; par_rx <= 1'b0; rx_data <= '0; rx_ready <= 1'b0;
      par_err <= 1'b0; ovr_err <= 1'b0; frm_err <= 1'b0; brk_det <= 1'b0;
    end else begin
      if (tick && rxd) armed <= 1'b1;
      if (rxd) brk_det <= 1'b0;
      if (err_clr) begin
        par_err <= 1'b0; ovr_err <= 1'b0; frm_err <= 1'b0;
      end
      if (data_rd) rx_ready <= 1'b0;
      if (!rx_en) st <= S_IDLE;
      else if (tick) begin
        case (st)
          S_IDLE: if (armed && !rxd) begin
            armed <= 1'b0; shreg <= '0; all_low <= 1'b1; idx <= '0;
            if (half == '0) begin st <= S_DATA;  cnt <= p - ONE;    end
            else            begin st <= S_START; cnt <= half - ONE; end
          end
          S_START: if (cnt == '0) begin
            if (!rxd) begin st <= S_DATA; cnt <= p - ONE; end
            else st <= S_IDLE;
          end else cnt <= cnt - ONE;
          S_DATA: if (cnt == '0) begin
            shreg[idx] <= rxd;
            if (rxd) all_low <= 1'b0;
            cnt <= p - ONE;
            if (last_bit) st <= par_en ? S_PAR : S_STOP;
            else idx <= idx + 3'd1;
          end else cnt <= cnt - ONE;
          S_PAR: if (cnt == '0) begin
            par_rx <= rxd;
            if (rxd) all_low <= 1'b0;
            st <= S_STOP; cnt <= p - ONE;
          end else cnt <= cnt - ONE;
          S_STOP: if (cnt == '0) begin
            st       <= S_IDLE;
            rx_data  <= shreg;
            rx_ready <= 1'b1;
            if (rx_ready && !data_rd) ovr_err <= 1'b1;
            if (!rxd) frm_err <= 1'b1;
            if (par_en && (par_rx != parity_of(shreg, len, even))) par_err <= 1'b1;
            if (all_low && !rxd) brk_det <= 1'b1;
          end else cnt <= cnt - ONE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_RXRDY_CLEAR: assert property (@(posedge clk) disable iff (clr)
    (data_rd && !char_done) |=> !rx_ready); // R8
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (clr)
    (char_done && rx_ready && !data_rd) |=> ovr_err); // R9
  AST_BRK_RELEASE: assert property (@(posedge clk) disable iff (clr)
    rxd |=> !brk_det); // R11
endmodule

// File: rtl/usart_core.sv
module usart_core
  import usart_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          cmd_sel,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  input  logic          baud_tick,
  input  logic          rxd,
  input  logic          cts_n,
  output logic          txd,
  output logic          tx_ready,
  output logic          tx_empty,
  output logic          rx_ready,
  output logic          brk_det,
  output logic          dtr_n,
  output logic          rts_n
);
  logic wr_q, rd_q, wr_lead, rd_lead;
  logic data_wr, ctrl_wr, data_rd;
  mode_t mode;
  logic tx_en, rx_en, brk, dtr, rts, err_clr, soft_rst, clr;
  logic buf_full, par_err, ovr_err, frm_err, char_done;
  logic [DW-1:0] rx_data, status;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= 1'b1; rd_q <= 1'b1;
    end else begin
      wr_q <= wr_n; rd_q <= rd_n;
    end
  end

  assign wr_lead = !cs_n && !wr_n && wr_q;
  assign rd_lead = !cs_n && !rd_n && rd_q;
  assign data_wr = wr_lead && !cmd_sel;
  assign ctrl_wr = wr_lead && cmd_sel;
  assign data_rd = rd_lead && !cmd_sel;
  assign clr     = rst || soft_rst;

  usart_ctrl u_ctrl (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .din(din), .mode(mode),
    .tx_en(tx_en), .rx_en(rx_en), .brk(brk), .dtr(dtr), .rts(rts),
    .err_clr(err_clr), .soft_rst(soft_rst)
  );

  usart_tx u_tx (
    .clk(clk), .clr(clr), .tick(baud_tick), .mode(mode), .tx_en(tx_en),
    .cts_n(cts_n), .brk(brk), .data_wr(data_wr), .din(din),
    .txd(txd), .buf_full(buf_full), .tx_empty(tx_empty)
  );

  usart_rx u_rx (
    .clk(clk), .clr(clr), .tick(baud_tick), .div(mode.div), .len(mode.len),
    .par_en(mode.par_en), .even(mode.even), .rx_en(rx_en), .rxd(rxd),
    .data_rd(data_rd), .err_clr(err_clr), .rx_data(rx_data),
    .rx_ready(rx_ready), .par_err(par_err), .ovr_err(ovr_err),
    .frm_err(frm_err), .brk_det(brk_det), .char_done(char_done)
  );

  assign status   = {1'b0, brk_det, frm_err, ovr_err, par_err, tx_empty, rx_ready, !buf_full};
  assign dout     = cmd_sel ? status : rx_data;
  assign tx_ready = !buf_full && tx_en && !cts_n;
  assign dtr_n    = !dtr;
  assign rts_n    = !rts;

  AST_TXD_MARK: assert property (@(posedge clk) disable iff (clr)
    (!tx_en && $past(!tx_en) && !brk) |-> txd); // R4
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst)
    brk |-> !txd); // R4
  AST_TXRDY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> (!tx_ready && !status[0])); // R5
  AST_TXE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> !tx_empty); // R6
endmodule

// File: tb/usart_core_test.sv
`timescale 1ns/1ps
module usart_core_test;
  localparam real CLK_NS = 8.0;

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cmd_sel = 1'b0;
  logic [7:0] din = '0, dout;
  logic baud_tick = 1'b1, rxd, rxd_drv = 1'b1, loop_en = 1'b0, cts_n = 1'b1;
  logic txd, tx_ready, tx_empty, rx_ready, brk_det, dtr_n, rts_n;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;
  assign rxd = loop_en ? txd : rxd_drv;

  usart_core uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .cmd_sel(cmd_sel),
    .din(din), .dout(dout), .baud_tick(baud_tick), .rxd(rxd), .cts_n(cts_n),
    .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty), .rx_ready(rx_ready),
    .brk_det(brk_det), .dtr_n(dtr_n), .rts_n(rts_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic sel, input logic [7:0] v);
    @(negedge clk);
    cs_n = 1'b0; cmd_sel = sel; din = v; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic bus_rd(input logic sel, output logic [7:0] v);
    @(negedge clk);
    cs_n = 1'b0; cmd_sel = sel; rd_n = 1'b0;
    #1 v = dout;
    @(negedge clk);
    rd_n = 1'b1; cs_n = 1'b1; cmd_sel = 1'b0;
  endtask

  task automatic drive_rx(input logic [7:0] d, input int nb, input bit pen,
                          input bit pbit, input bit stopv, input int p);
    rxd_drv = 1'b0; clks(p);
    for (int i = 0; i < nb; i++) begin rxd_drv = d[i]; clks(p); end
    if (pen) begin rxd_drv = pbit; clks(p); end
    rxd_drv = stopv; clks(p);
    rxd_drv = 1'b1;
  endtask

  initial begin
    #(CLK_NS * 195000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, exp_d, m;
    logic [10:0] frame;
    bit seen;
    clks(5); rst = 1'b0; clks(2);

    // reset state
    chk("R4 txd mark after reset", txd, 1);
    chk("R5 tx_ready pin low while disabled", tx_ready, 0);
    chk("R11 brk_det low after reset", brk_det, 0);
    chk("R12 dtr_n/rts_n idle", {dtr_n, rts_n}, 2'b11);
    bus_rd(1, v); chk("R1 status after reset", v, 8'h05);

    // mode: x16, 7 bits, even parity, 2 stops -> 0xFA
    bus_wr(1, 8'hFA);
    bus_wr(1, 8'h22);
    chk("R12 dtr_n/rts_n asserted by command", {dtr_n, rts_n}, 2'b00);
    chk("R4 txd mark while transmit disabled", txd, 1);
    bus_wr(1, 8'h01);
    chk("R2 later control write is a command", {dtr_n, rts_n}, 2'b11);
    chk("R5 pin gated by cts_n high", tx_ready, 0);
    bus_rd(1, v); chk("R5 status bit0 ignores cts_n", v[0], 1);
    cts_n = 1'b0; clks(1);
    chk("R5 pin high with cts_n low", tx_ready, 1);
    cts_n = 1'b1;
    bus_wr(0, 8'h53);
    bus_rd(1, v);
    chk("R5 status bit0 clears on write", v[0], 0);
    chk("R6 tx_empty clears on write", v[2], 0);
    clks(40);
    chk("R7 no frame while cts_n high", txd, 1);
    cts_n = 1'b0;
    seen = 0;
    for (int i = 0; i < 50 && !seen; i++) begin @(negedge clk); if (!txd) seen = 1; end
    chk("R7 frame starts after cts_n low", seen, 1);
    exp_d = 8'h53 & 8'h7F;
    frame = {2'b11, ~($countones(exp_d) % 2 == 1) ? 1'b0 : 1'b1, exp_d[6:0], 1'b0};
    clks(8);
    chk("R7 start bit", txd, frame[0]);
    for (int k = 1; k < 11; k++) begin
      clks(16);
      chk($sformatf("R7 frame bit %0d (R3 x16 7E2)", k), txd, frame[k]);
    end
    clks(14);
    chk("R6 tx_empty after frame", tx_empty, 1);
    bus_wr(1, 8'h09);
    chk("R4 break forces txd low", txd, 0);
    bus_wr(1, 8'h01);
    chk("R4 txd returns high after break", txd, 1);

    // receiver: internal reset, mode x16 8N1 = 0x4E
    bus_wr(1, 8'h40);
    chk("R2 internal reset clears tx enable", tx_ready, 0);
    bus_rd(1, v); chk("R2 status after internal reset", v, 8'h05);
    bus_wr(1, 8'h4E);
    bus_wr(1, 8'h04);
    clks(4);
    drive_rx(8'h3C, 8, 0, 0, 1, 16); clks(4);
    chk("R8 rx_ready set", rx_ready, 1);
    bus_rd(1, v); chk("R8 status bit1 set, no errors", v & 8'h7A, 8'h02);
    bus_rd(0, v); chk("R8 received data", v, 8'h3C);
    chk("R8 rx_ready cleared by read", rx_ready, 0);

    drive_rx(8'h81, 8, 0, 0, 0, 16); clks(4);
    bus_rd(1, v); chk("R10 framing flag", v[5], 1);
    bus_rd(0, v); chk("R10 data with framing error", v, 8'h81);
    bus_wr(1, 8'h14);
    bus_rd(1, v); chk("R10 error reset clears framing", v[5], 0);

    drive_rx(8'h11, 8, 0, 0, 1, 16);
    drive_rx(8'h22, 8, 0, 0, 1, 16); clks(4);
    bus_rd(1, v); chk("R9 overrun flag", v[4], 1);
    bus_rd(0, v); chk("R9 newer character kept", v, 8'h22);
    bus_wr(1, 8'h14);

    rxd_drv = 1'b0; clks(11 * 16 + 20);
    chk("R11 brk_det high on held-low line", brk_det, 1);
    bus_rd(1, v); chk("R11 status break and framing", v[6:5], 2'b11);
    rxd_drv = 1'b1; clks(1);
    chk("R11 brk_det falls when rxd high", brk_det, 0);
    bus_rd(0, v); chk("R1 break character reads zero", v, 8'h00);

    // parity: x16 8 bits even parity -> 0x7E
    bus_wr(1, 8'h40); bus_wr(1, 8'h7E); bus_wr(1, 8'h04); clks(4);
    drive_rx(8'h3C, 8, 1, 1, 1, 16); clks(4);
    bus_rd(1, v); chk("R10 parity flag on mismatch", v[3], 1);
    bus_rd(0, v); chk("R10 data with parity error", v, 8'h3C);
    bus_wr(1, 8'h14);
    drive_rx(8'h3C, 8, 1, 0, 1, 16); clks(4);
    bus_rd(1, v); chk("R10 no parity flag on match", v[3], 0);
    bus_rd(0, v);

    // loopback sweep over every mode byte
    loop_en = 1'b1; cts_n = 1'b0;
    for (int d = 1; d < 4; d++)
      for (int l = 0; l < 4; l++)
        for (int pm = 0; pm < 3; pm++)
          for (int s = 1; s < 4; s++) begin
            m = {s[1:0], (pm == 2) ? 1'b1 : 1'b0, (pm != 0) ? 1'b1 : 1'b0, l[1:0], d[1:0]};
            exp_d = 8'(8'h5A + d * 29 + l * 53 + pm * 11 + s * 7);
            bus_wr(1, 8'h40); bus_wr(1, m); bus_wr(1, 8'h25); clks(2);
            bus_wr(0, exp_d);
            seen = 0;
            for (int t = 0; t < 2000 && !seen; t++) begin @(negedge clk); if (rx_ready) seen = 1; end
            bus_rd(1, v);
            chk($sformatf("R3 R7 R8 loopback mode %02h ready/no errors", m), v & 8'h3A, 8'h02);
            bus_rd(0, v);
            chk($sformatf("R3 R1 loopback mode %02h data", m), v,
                exp_d & 8'((1 << (5 + l)) - 1));
          end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule